// File: doc/BRIEF.md
# Time-Stamp Counter with Privileged and Register Access

This block keeps a 64-bit time stamp that advances by one on each cycle in which a constant-rate reference tick is present. Processor logic samples it to stamp events. Two paths read it. The first is a user read path: a requester presents its privilege level, and a restriction flag can confine reads to privilege level 0. The second is a generic model-specific-register bus, where the counter is decoded at one fixed address and can be both read and written.

A build parameter selects how register writes load the counter. In the narrow mode, only the lower 32 bits come from the write data and the upper half is forced to zero. In the wide mode, all 64 bits are loaded. When the invariant mode input is set, a power-state input has no influence on counting. When that input is clear, halted and throttled power states freeze the count. A constant capability word reports through bit 8 whether the build supports invariant counting.

Top module: `tsc_unit`

## Requirements
- R1: While rst_n is low the counter is cleared to zero and user_rd_valid, user_rd_fault and reg_rd_valid are low.
- R2: The counter advances by exactly one on each cycle in which the advance condition holds and no register write hits it; all ones advances to zero, and no other discontinuity exists.
- R3: A user read request in cycle t produces user_rd_valid high in cycle t+1, with user_rd_data equal to the counter value held during cycle t.
- R4: A user read with restrict_en high and user_pl not 0 produces, in cycle t+1, user_rd_fault high for one cycle, user_rd_valid low and user_rd_data zero; with restrict_en low, any privilege level is served as in R3.
- R5: A register read with reg_addr equal to 0x010 produces, one cycle later, reg_rd_valid high and reg_rd_data equal to all 64 bits of the counter value of the request cycle, the same value a user read in that cycle returns.
- R6: With FULL_WRITE = 0, a register write to 0x010 loads reg_wdata[31:0] into the low half and zero into the upper 32 bits.
- R7: With FULL_WRITE = 1, a register write to 0x010 loads all 64 bits of reg_wdata.
- R8: A register write to 0x010 takes priority over an advance in the same cycle; the written value is the counter value of the next cycle, and counting continues from it.
- R9: A register write to any address other than 0x010 leaves the counter unchanged, and a register read at such an address returns zero data with reg_rd_valid high.
- R10: With invariant_en high, the counter advances on every cycle in which tick_en is high, whatever pwr_state shows.
- R11: With invariant_en low, the counter does not advance while pwr_state is 1 (halted) or 2 (throttled); states 0 (running) and 3 (idle) allow counting.
- R12: cap_word bit 8 equals the INVARIANT_CAP parameter and every other bit of cap_word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_en | input | 1 | Constant-rate reference tick enable |
| invariant_en | input | 1 | When high, pwr_state is ignored for counting |
| pwr_state | input | 2 | 0 running, 1 halted, 2 throttled, 3 idle |
| user_rd_req | input | 1 | User read request |
| user_pl | input | 2 | Privilege level of the requester |
| restrict_en | input | 1 | Confines user reads to privilege level 0 |
| user_rd_valid | output | 1 | User read data valid, one cycle after request |
| user_rd_fault | output | 1 | User read refused |
| user_rd_data | output | 64 | User read data |
| reg_rd_en | input | 1 | Register bus read strobe |
| reg_wr_en | input | 1 | Register bus write strobe |
| reg_addr | input | 12 | Register bus address |
| reg_wdata | input | 64 | Register bus write data |
| reg_rd_valid | output | 1 | Register read data valid |
| reg_rd_data | output | 64 | Register read data |
| cap_word | output | 32 | Capability word; bit 8 reports invariant support |

## Verification
The counter is run with long stretches of ticks and with ticks gated by each power-state code, both with and without invariant mode, so that a frozen count can be told apart from a free-running one. Both write modes are instantiated side by side and written with the same patterns, including an all-ones value followed by a tick, which separates a cleared upper half from a full load and shows the wrap to zero. User reads sweep every privilege level with the restriction flag both set and clear, which separates served reads from faults. Register accesses mix the counter address with neighbouring addresses, so that a decode that is too loose shows up. Seeded random mixes of all inputs are then checked against a bench model.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    PS_RUN      = 2'd0,
    PS_HALT     = 2'd1,
    PS_THROTTLE = 2'd2,
    PS_IDLE     = 2'd3
  } pwr_state_e;

  localparam int CAP_W       = 32;
  localparam int CAP_INV_BIT = 8;

  function automatic logic state_freezes(input logic [1:0] ps);
    return (ps == PS_HALT) || (ps == PS_THROTTLE);
  endfunction

endpackage

// File: rtl/tsc_advance_gate.sv
module tsc_advance_gate
  import tsc_pkg::*;
(
  input  logic       tick_en,
  input  logic       invariant_en,
  input  logic [1:0] pwr_state,
  output logic       advance
);

  logic frozen;

  always_comb begin
    frozen  = state_freezes(pwr_state) && !invariant_en;
    advance = tick_en && !frozen;
  end

endmodule

// File: rtl/tsc_counter.sv
module tsc_counter #(
  parameter int CNT_W      = 64,
  parameter bit FULL_WRITE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             wr_hit,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt
);

  localparam int LOW_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  localparam logic [CNT_W-1:0] LOAD_MASK =
    FULL_WRITE ? {CNT_W{1'b1}} : {{(CNT_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = wr_hit || advance;
    if (wr_hit) begin
      cnt_d = wdata & LOAD_MASK;
    end else begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R2: step of exactly one when advancing without a write
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !wr_hit) |=> (cnt_q == $past(cnt_q) + ONE));

  // R2: no change when neither advancing nor written
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !wr_hit) |=> $stable(cnt_q));

  generate
    if (FULL_WRITE) begin : g_full
      // R7: all bits loaded
      p_full_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cnt_q == $past(wdata)));
    end else begin : g_legacy
      // R6: upper half cleared, low half loaded
      p_legacy_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cnt_q[CNT_W-1:LOW_W] == '0));
      p_legacy_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (cnt_q[LOW_W-1:0] == $past(wdata[LOW_W-1:0])));
    end
  endgenerate

endmodule

// File: rtl/tsc_user_port.sv
module tsc_user_port #(
  parameter int CNT_W = 64,
  parameter int PL_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [PL_W-1:0]  pl,
  input  logic             restrict_en,
  input  logic [CNT_W-1:0] cnt,
  output logic             valid,
  output logic             fault,
  output logic [CNT_W-1:0] data
);

  logic             deny;
  logic             valid_d, fault_d;
  logic [CNT_W-1:0] data_d;
  logic             valid_q, fault_q;
  logic [CNT_W-1:0] data_q;

  always_comb begin
    deny    = restrict_en && (pl != '0);
    valid_d = req && !deny;
    fault_d = req && deny;
    data_d  = valid_d ? cnt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      fault_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      fault_q <= fault_d;
      data_q  <= data_d;
    end
  end

  assign valid = valid_q;
  assign fault = fault_q;
  assign data  = data_q;

  // R4: a refused read never also reports valid
  p_fault_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_q && fault_q));

  // R4: a refused read carries no counter bits
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fault_q |-> (data_q == '0));

  // R4: privilege level 0 is always served
  p_pl0_served_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && pl == '0) |=> (valid_q && !fault_q));

  // R3: returned data is the counter value of the request cycle
  p_read_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !restrict_en) |=> (data_q == $past(cnt)));

endmodule

// File: rtl/tsc_reg_port.sv
module tsc_reg_port #(
  parameter int              CNT_W    = 64,
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] TSC_ADDR = 12'h010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic              wr_hit,
  output logic              rd_valid,
  output logic [CNT_W-1:0]  rd_data
);

  logic             addr_hit;
  logic [CNT_W-1:0] rd_data_d;
  logic             rd_valid_q;
  logic [CNT_W-1:0] rd_data_q;

  always_comb begin
    addr_hit  = (addr == TSC_ADDR);
    wr_hit    = wr_en && addr_hit;
    rd_data_d = (rd_en && addr_hit) ? cnt : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_data_q  <= rd_data_d;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R9: reads off the counter address return zero
  p_offaddr_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr != TSC_ADDR) |=> (rd_valid_q && rd_data_q == '0));

  // R5: reads at the counter address return the full count
  p_hit_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == TSC_ADDR) |=> (rd_valid_q && rd_data_q == $past(cnt)));

endmodule

// File: rtl/tsc_unit.sv
module tsc_unit
  import tsc_pkg::*;
#(
  parameter int                CNT_W         = 64,
  parameter int                PL_W          = 2,
  parameter int                ADDR_W        = 12,
  parameter logic [ADDR_W-1:0] TSC_ADDR      = 12'h010,
  parameter bit                FULL_WRITE    = 1'b0,
  parameter bit                INVARIANT_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              invariant_en,
  input  logic [1:0]        pwr_state,
  input  logic              user_rd_req,
  input  logic [PL_W-1:0]   user_pl,
  input  logic              restrict_en,
  output logic              user_rd_valid,
  output logic              user_rd_fault,
  output logic [CNT_W-1:0]  user_rd_data,
  input  logic              reg_rd_en,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CNT_W-1:0]  reg_wdata,
  output logic              reg_rd_valid,
  output logic [CNT_W-1:0]  reg_rd_data,
  output logic [CAP_W-1:0]  cap_word
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             advance;
  logic             wr_hit;
  logic [CNT_W-1:0] cnt;

  tsc_advance_gate u_gate (
    .tick_en      (tick_en),
    .invariant_en (invariant_en),
    .pwr_state    (pwr_state),
    .advance      (advance)
  );

  tsc_counter #(
    .CNT_W      (CNT_W),
    .FULL_WRITE (FULL_WRITE)
  ) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .wr_hit  (wr_hit),
    .wdata   (reg_wdata),
    .cnt     (cnt)
  );

  tsc_user_port #(
    .CNT_W (CNT_W),
    .PL_W  (PL_W)
  ) u_user (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (user_rd_req),
    .pl          (user_pl),
    .restrict_en (restrict_en),
    .cnt         (cnt),
    .valid       (user_rd_valid),
    .fault       (user_rd_fault),
    .data        (user_rd_data)
  );

  tsc_reg_port #(
    .CNT_W    (CNT_W),
    .ADDR_W   (ADDR_W),
    .TSC_ADDR (TSC_ADDR)
  ) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (reg_rd_en),
    .wr_en    (reg_wr_en),
    .addr     (reg_addr),
    .cnt      (cnt),
    .wr_hit   (wr_hit),
    .rd_valid (reg_rd_valid),
    .rd_data  (reg_rd_data)
  );

  always_comb begin
    cap_word              = '0;
    cap_word[CAP_INV_BIT] = INVARIANT_CAP;
  end

  // R10: invariant mode counts on every tick regardless of power state
  p_invariant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (invariant_en && tick_en && !(reg_wr_en && reg_addr == TSC_ADDR))
      |=> (cnt == $past(cnt) + ONE));

  // R11: halted or throttled state freezes the count outside invariant mode
  p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!invariant_en && state_freezes(pwr_state) && !(reg_wr_en && reg_addr == TSC_ADDR))
      |=> $stable(cnt));

  // R9: writes elsewhere do not touch the count
  p_offaddr_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != TSC_ADDR && !tick_en) |=> $stable(cnt));

endmodule

// File: tb/tsc_unit_bench.sv
`timescale 1ns/1ps
module tsc_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_en, invariant_en, user_rd_req, restrict_en;
  logic [1:0]  pwr_state, user_pl;
  logic        reg_rd_en, reg_wr_en;
  logic [11:0] reg_addr;
  logic [63:0] reg_wdata;

  logic        uv_l, uf_l, rv_l, uv_f, uf_f, rv_f;
  logic [63:0] ud_l, rd_l, ud_f, rd_f;
  logic [31:0] cap_l, cap_f;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] m_l, m_f;

  always #2.5 clk = ~clk;

  tsc_unit #(.FULL_WRITE(1'b0), .INVARIANT_CAP(1'b1)) u_tsc_unit (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .invariant_en(invariant_en),
    .pwr_state(pwr_state), .user_rd_req(user_rd_req), .user_pl(user_pl),
    .restrict_en(restrict_en), .user_rd_valid(uv_l), .user_rd_fault(uf_l),
    .user_rd_data(ud_l), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_valid(rv_l),
    .reg_rd_data(rd_l), .cap_word(cap_l));

  tsc_unit #(.FULL_WRITE(1'b1), .INVARIANT_CAP(1'b0)) u_tsc_unit_full (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .invariant_en(invariant_en),
    .pwr_state(pwr_state), .user_rd_req(user_rd_req), .user_pl(user_pl),
    .restrict_en(restrict_en), .user_rd_valid(uv_f), .user_rd_fault(uf_f),
    .user_rd_data(ud_f), .reg_rd_en(reg_rd_en), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rd_valid(rv_f),
    .reg_rd_data(rd_f), .cap_word(cap_f));

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] next_val(input logic [63:0] cur, input bit full,
      input logic t, input logic inv, input logic [1:0] ps,
      input logic wr, input logic [11:0] a, input logic [63:0] wd);
    if (wr && a == 12'h010) return full ? wd : {32'h0, wd[31:0]};
    if (t && (inv || !(ps == 2'd1 || ps == 2'd2))) return cur + 64'd1;
    return cur;
  endfunction

  // one clock: inputs already driven; model updated at the edge, outputs checked at the next falling edge
  task automatic step(input string ctx);
    logic        deny, urq, rrq;
    logic [11:0] a;
    logic [63:0] old_l, old_f;
    @(posedge clk);
    deny  = restrict_en && (user_pl != 2'd0);
    urq   = user_rd_req;
    rrq   = reg_rd_en;
    a     = reg_addr;
    old_l = m_l;
    old_f = m_f;
    m_l = next_val(m_l, 1'b0, tick_en, invariant_en, pwr_state, reg_wr_en, reg_addr, reg_wdata);
    m_f = next_val(m_f, 1'b1, tick_en, invariant_en, pwr_state, reg_wr_en, reg_addr, reg_wdata);
    @(negedge clk);
    if (urq) begin
      check(deny ? "R4" : "R3", {ctx, " user valid"}, {63'h0, uv_l}, {63'h0, !deny});
      check(deny ? "R4" : "R3", {ctx, " user fault"}, {63'h0, uf_l}, {63'h0, deny});
      check(deny ? "R4" : "R3", {ctx, " user data narrow"}, ud_l, deny ? 64'h0 : old_l);
      check(deny ? "R4" : "R3", {ctx, " user data wide"}, ud_f, deny ? 64'h0 : old_f);
    end else begin
      check("R3", {ctx, " user idle"}, {62'h0, uv_f, uf_f}, 64'h0);
    end
    check("R5", {ctx, " reg valid"}, {63'h0, rv_l}, {63'h0, rrq});
    if (rrq) begin
      check(a == 12'h010 ? "R5" : "R9", {ctx, " reg data narrow"}, rd_l,
            a == 12'h010 ? old_l : 64'h0);
      check(a == 12'h010 ? "R5" : "R9", {ctx, " reg data wide"}, rd_f,
            a == 12'h010 ? old_f : 64'h0);
    end
  endtask

  task automatic idle_inputs();
    tick_en = 0; user_rd_req = 0; reg_rd_en = 0; reg_wr_en = 0;
    reg_addr = 12'h0; reg_wdata = 64'h0; user_pl = 2'd0;
  endtask

  task automatic uread(input logic [1:0] pl, input logic rs, input string ctx);
    idle_inputs();
    user_rd_req = 1; user_pl = pl; restrict_en = rs;
    step(ctx);
  endtask

  task automatic rread(input logic [11:0] a, input string ctx);
    idle_inputs();
    reg_rd_en = 1; reg_addr = a;
    step(ctx);
  endtask

  task automatic rwrite(input logic [11:0] a, input logic [63:0] d,
                        input logic t, input string ctx);
    idle_inputs();
    reg_wr_en = 1; reg_addr = a; reg_wdata = d; tick_en = t;
    step(ctx);
  endtask

  task automatic ticks(input int n, input logic inv, input logic [1:0] ps, input string ctx);
    for (int i = 0; i < n; i++) begin
      idle_inputs();
      tick_en = 1; invariant_en = inv; pwr_state = ps;
      step(ctx);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle_inputs();
    invariant_en = 0; pwr_state = 2'd0; restrict_en = 0;
    m_l = 64'h0; m_f = 64'h0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", "reset outputs", {58'h0, uv_l, uf_l, rv_l, uv_f, uf_f, rv_f}, 64'h0);
    rst_n = 1;
    uread(2'd0, 1'b0, "R1 count after reset");

    check("R12", "cap narrow", {32'h0, cap_l}, 64'h100);
    check("R12", "cap wide", {32'h0, cap_f}, 64'h0);

    ticks(10, 1'b0, 2'd0, "R2 run");
    uread(2'd3, 1'b0, "R2 ten ticks");

    for (int p = 0; p < 4; p++) begin
      uread(p[1:0], 1'b1, "R4 restricted");
      uread(p[1:0], 1'b0, "R4 open");
    end

    rread(12'h010, "R5 hit");
    rread(12'h011, "R9 near miss");
    rread(12'h810, "R9 high miss");
    rwrite(12'h020, 64'hFFFF_0000_1234_5678, 1'b0, "R9 write elsewhere");
    rread(12'h010, "R9 unchanged");

    rwrite(12'h010, 64'hDEAD_BEEF_CAFE_F00D, 1'b1, "R8 write with tick");
    uread(2'd0, 1'b0, "R6 R7 R8 loaded value");
    ticks(3, 1'b0, 2'd0, "R8 resume");
    rread(12'h010, "R8 resumed");

    rwrite(12'h010, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R2 all ones");
    ticks(1, 1'b0, 2'd0, "R2 wrap tick");
    rread(12'h010, "R2 wrap R6 carry");

    ticks(5, 1'b0, 2'd1, "R11 halted");
    ticks(5, 1'b0, 2'd2, "R11 throttled");
    ticks(4, 1'b0, 2'd3, "R11 idle counts");
    uread(2'd0, 1'b0, "R11 after states");
    ticks(6, 1'b1, 2'd1, "R10 halted invariant");
    ticks(6, 1'b1, 2'd2, "R10 throttled invariant");
    uread(2'd0, 1'b0, "R10 after states");

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      tick_en      = r[0] | r[1];
      invariant_en = r[2];
      pwr_state    = r[4:3];
      user_rd_req  = r[5];
      user_pl      = r[7:6];
      restrict_en  = r[8];
      reg_rd_en    = r[9];
      reg_wr_en    = (r[13:10] == 4'd0);
      reg_addr     = r[14] ? 12'h010 : {r[25:16], 2'b00};
      reg_wdata    = {$urandom, $urandom};
      if (r[31:28] == 4'hF) reg_wdata = 64'hFFFF_FFFF_FFFF_FFFE;
      step("random");
    end

    idle_inputs();
    uread(2'd0, 1'b0, "R2 final");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule